// File: doc/BRIEF.md
# Dual-Generator Output Locking Wrapper

This block is a purely combinational lock that sits on one protected output bit of a small combinational circuit. It takes the circuit's primary inputs, the unprotected output bit and a key vector. It returns the locked output, which is the unprotected bit XORed with a flip term. Two flip generators run side by side, and the flip term is the OR of their outputs.

The first generator is a single-point comparator. It fires when the low input bits equal the point key, and it is silenced when the point key equals its built-in correct value. The second generator is a balanced binary tree. Each leaf is the XNOR of one input bit with one tree-key bit. A plain AND tree would give a single-point function. A parameter tuple (gate kind, layer, count) replaces the first `count` gates of one layer with XOR, OR or NAND gates, which turns the tree into a multi-point function. The tree flip is silenced when the tree key equals its built-in correct value.

There is no clock, no state and no handshake. Values move straight from the inputs to the output, so a stream interface would add latency and nothing else. Key widths, correct keys and the replacement tuple are fixed at elaboration. A tree width that is not a power of two, a layer that does not exist, a count larger than the chosen layer, or an input width narrower than either key is rejected at elaboration.

Top module: `dual_flip_lock`

## Requirements
- R1: `y_out` equals `y_in` XOR (point flip OR tree flip). Whenever either flip is active, `y_out` differs from `y_in`.
- R2: When `key_in` holds both correct keys, `y_out` equals `y_in` for every value of `pi_in`.
- R3: The point key is `key_in[PW-1:0]`. When the tree key is correct and the point key is wrong, exactly one input pattern over all of `pi_in` inverts the output: the one where `pi_in[PW-1:0]` equals the point key.
- R4: When the point key is correct, the point generator never fires, even when `pi_in[PW-1:0]` equals that key.
- R5: Tree leaf i is XNOR(`pi_in[i]`, tree key bit i). Layer 0 joins leaf pairs (0,1),(2,3),... and the next layer joins their results in the same way. The first REPL_COUNT gates of layer REPL_LAYER use REPL_GATE, and all other gates are AND. With the defaults (width 4, both layer-0 gates XOR), the tree fires when leaf0≠leaf1 and leaf2≠leaf3.
- R6: The tree key is `key_in[PW+TW-1:PW]`. When the tree key is correct, the tree generator never fires.
- R7: The two flips are combined by OR. When both are active on the same pattern, the output is inverted once and not twice.
- R8: With the defaults, a correct point key and any wrong tree key, exactly 2048 of the 8192 input patterns invert the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pi_in | input | N_IN | Primary inputs of the protected circuit |
| y_in | input | 1 | Unprotected output bit |
| key_in | input | PW+TW | Key vector: point key in low bits, tree key above it |
| y_out | output | 1 | Locked output bit |

## Verification
The bench builds the block with its defaults: a 13-bit input, a 13-bit point key, and a 4-bit tree whose two layer-0 gates are XOR. With these values every input pattern can be swept for each key the bench tries. That full sweep makes exact counts possible: one flipped pattern for a wrong point key, 2048 for a wrong tree key, and their union when both keys are wrong. The sweep also shows that the all-matching pattern no longer fires once the XOR replacement is in place.

// File: rtl/lock_pkg.sv
package lock_pkg;
  typedef enum logic [1:0] {
    GATE_AND  = 2'd0,
    GATE_XOR  = 2'd1,
    GATE_OR   = 2'd2,
    GATE_NAND = 2'd3
  } gate_t;
endpackage

// File: rtl/point_flip.sv
module point_flip #(
  parameter int             W      = 13,
  parameter logic [W-1:0]   KEY_OK = '0
) (
  input  logic [W-1:0] in_bits,
  input  logic [W-1:0] key,
  output logic         flip
);
  logic hit;
  logic key_good;

  assign hit      = (in_bits == key);
  assign key_good = (key == KEY_OK);
  assign flip     = hit & ~key_good;

  always_comb begin
    // R3: a firing comparator always sits on the key's own pattern
    p_single_point_r3: assert (!flip || (in_bits == key))
      else $error("point flip away from key pattern");
    // R4: the correct key silences this generator
    p_point_mask_r4: assert (!(key == KEY_OK) || !flip)
      else $error("point flip under correct key");
  end
endmodule

// File: rtl/tree_node.sv
module tree_node #(
  parameter lock_pkg::gate_t KIND = lock_pkg::GATE_AND
) (
  input  logic a,
  input  logic b,
  output logic z
);
  if (KIND == lock_pkg::GATE_XOR) begin : g_xor
    assign z = a ^ b;
  end else if (KIND == lock_pkg::GATE_OR) begin : g_or
    assign z = a | b;
  end else if (KIND == lock_pkg::GATE_NAND) begin : g_nand
    assign z = ~(a & b);
  end else begin : g_and
    assign z = a & b;
  end
endmodule

// File: rtl/tree_flip.sv
module tree_flip #(
  parameter int              TW     = 4,
  parameter logic [TW-1:0]   KEY_OK = '0,
  parameter lock_pkg::gate_t GATE   = lock_pkg::GATE_XOR,
  parameter int              LAYER  = 0,
  parameter int              COUNT  = 2
) (
  input  logic [TW-1:0] in_bits,
  input  logic [TW-1:0] key,
  output logic          flip
);
  localparam int LEVELS = $clog2(TW);
  localparam int NODES  = 2 * TW - 1;
  localparam int ROOT   = NODES - 1;

  if ((TW < 2) || ((TW & (TW - 1)) != 0)) begin : g_bad_width
    $error("tree width must be a power of two, at least 2");
  end
  if ((LAYER < 0) || (LAYER >= LEVELS)) begin : g_bad_layer
    $error("replacement layer outside the tree");
  end else if ((COUNT < 0) || (COUNT > (TW >> (LAYER + 1)))) begin : g_bad_count
    $error("replacement count exceeds gates in layer");
  end

  // heap-ordered node vector: leaves first, each layer after the one below
  logic [NODES-1:0] node;
  logic             tree_hit;
  logic             key_good;

  assign node[TW-1:0] = ~(in_bits ^ key);

  for (genvar l = 0; l < LEVELS; l++) begin : g_layer
    localparam int IB  = 2 * TW - 2 * (TW >> l);
    localparam int OB  = 2 * TW - 2 * (TW >> (l + 1));
    localparam int NG  = TW >> (l + 1);
    for (genvar g = 0; g < NG; g++) begin : g_gate
      localparam lock_pkg::gate_t KIND =
        ((l == LAYER) && (g < COUNT)) ? GATE : lock_pkg::GATE_AND;
      tree_node #(.KIND(KIND)) u_node (
        .a (node[IB + 2*g]),
        .b (node[IB + 2*g + 1]),
        .z (node[OB + g])
      );
    end
  end

  assign tree_hit = node[ROOT];
  assign key_good = (key == KEY_OK);
  assign flip     = tree_hit & ~key_good;

  always_comb begin
    // R6: the correct tree key silences this generator
    p_tree_mask_r6: assert (!(key == KEY_OK) || !flip)
      else $error("tree flip under correct key");
  end
endmodule

// File: rtl/dual_flip_lock.sv
module dual_flip_lock #(
  parameter int              N_IN       = 13,
  parameter int              PW         = 13,
  parameter int              TW         = 4,
  parameter logic [PW-1:0]   PT_KEY_OK  = 13'h1A5C,
  parameter logic [TW-1:0]   TR_KEY_OK  = 4'h9,
  parameter lock_pkg::gate_t REPL_GATE  = lock_pkg::GATE_XOR,
  parameter int              REPL_LAYER = 0,
  parameter int              REPL_COUNT = 2
) (
  input  logic [N_IN-1:0]  pi_in,
  input  logic             y_in,
  input  logic [PW+TW-1:0] key_in,
  output logic             y_out
);
  localparam int KW = PW + TW;

  if ((N_IN < PW) || (N_IN < TW)) begin : g_bad_inputs
    $error("input width narrower than a key section");
  end

  logic [PW-1:0] pt_key;
  logic [TW-1:0] tr_key;
  logic          pt_flip;
  logic          tr_flip;
  logic          flip_any;

  assign pt_key = key_in[PW-1:0];
  assign tr_key = key_in[KW-1:PW];

  point_flip #(.W(PW), .KEY_OK(PT_KEY_OK)) u_point (
    .in_bits (pi_in[PW-1:0]),
    .key     (pt_key),
    .flip    (pt_flip)
  );

  tree_flip #(
    .TW(TW), .KEY_OK(TR_KEY_OK), .GATE(REPL_GATE),
    .LAYER(REPL_LAYER), .COUNT(REPL_COUNT)
  ) u_tree (
    .in_bits (pi_in[TW-1:0]),
    .key     (tr_key),
    .flip    (tr_flip)
  );

  assign flip_any = pt_flip | tr_flip;
  assign y_out    = y_in ^ flip_any;

  always_comb begin
    // R1: any active generator inverts the protected bit
    p_flip_inverts_r1: assert (!(pt_flip || tr_flip) || (y_out != y_in))
      else $error("flip active but output not inverted");
    // R2: both correct keys restore the original function
    p_correct_key_r2: assert (!(key_in == {TR_KEY_OK, PT_KEY_OK}) || (y_out == y_in))
      else $error("correct key altered output");
    // R7: both flips together still yield one inversion
    p_single_inv_r7: assert (!(pt_flip && tr_flip) || (y_out == ~y_in))
      else $error("double flip cancelled");
  end
endmodule

// File: tb/dual_flip_lock_tb_top.sv
module dual_flip_lock_tb_top;
  localparam logic [12:0] KP_OK = 13'h1A5C;
  localparam logic [3:0]  KT_OK = 4'h9;

  logic        clk = 1'b0;
  logic [12:0] pi_in = '0;
  logic        y_in = 1'b0;
  logic [16:0] key_in = {KT_OK, KP_OK};
  logic        y_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  dual_flip_lock dut_i (
    .pi_in  (pi_in),
    .y_in   (y_in),
    .key_in (key_in),
    .y_out  (y_out)
  );

  // {x[13], point key[13], tree key[4], y_in, expected y_out}
  localparam int NV = 9;
  localparam logic [31:0] VEC [NV] = '{
    {13'h0000, 13'h1A5C, 4'h9, 1'b0, 1'b0},  // R2 correct keys
    {13'h1A5C, 13'h1A5C, 4'h9, 1'b1, 1'b1},  // R4 correct key on its pattern
    {13'h0123, 13'h0123, 4'h9, 1'b0, 1'b1},  // R3 wrong point key hit
    {13'h0124, 13'h0123, 4'h9, 1'b1, 1'b1},  // R3 neighbour pattern
    {13'h0001, 13'h1A5C, 4'h0, 1'b0, 1'b0},  // R5 tree miss
    {13'h0005, 13'h1A5C, 4'h0, 1'b0, 1'b1},  // R5 tree hit
    {13'h0006, 13'h1A5C, 4'h0, 1'b1, 1'b0},  // R5 tree hit, y=1
    {13'h0000, 13'h1A5C, 4'h0, 1'b1, 1'b1},  // R5 all-match no longer fires
    {13'h0005, 13'h0005, 4'h0, 1'b0, 1'b1}   // R7 both flips, one inversion
  };

  function automatic logic model_flip(logic [12:0] x, logic [12:0] kp, logic [3:0] kt);
    logic pf, tf;
    logic [3:0] lf;
    pf = (x == kp) && (kp != KP_OK);
    lf = ~(x[3:0] ^ kt);
    tf = ((lf[0] ^ lf[1]) & (lf[2] ^ lf[3])) && (kt != KT_OK);
    return pf | tf;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(logic [12:0] x, logic [16:0] k, logic y);
    @(posedge clk);
    #1;
    pi_in  = x;
    key_in = k;
    y_in   = y;
    #1;
  endtask

  // full sweep of the input space; counts inverted patterns and model mismatches
  task automatic sweep(logic [12:0] kp, logic [3:0] kt,
                       output int flips, output int mism, output int first_x);
    flips = 0; mism = 0; first_x = -1;
    for (int x = 0; x < 8192; x++) begin
      logic yv, e;
      yv = ^x[12:0];
      apply(x[12:0], {kt, kp}, yv);
      e = yv ^ model_flip(x[12:0], kp, kt);
      if (y_out != yv) begin
        flips++;
        if (first_x < 0) first_x = x;
      end
      if (y_out != e) mism++;
    end
  endtask

  initial begin
    int fl, mm, fx;
    #1;
    check("R2 initial correct-key output", y_out, 0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][31:19], {VEC[i][5:2], VEC[i][18:6]}, VEC[i][1]);
      check($sformatf("R1 vector %0d", i), y_out, VEC[i][0]);
    end

    sweep(KP_OK, KT_OK, fl, mm, fx);
    check("R2 correct keys flip count", fl, 0);

    sweep(13'h0123, KT_OK, fl, mm, fx);
    check("R3 wrong point key flip count", fl, 1);
    check("R3 flipped pattern equals key", fx, 32'h0123);
    check("R1 point sweep vs model", mm, 0);

    sweep(KP_OK, 4'h0, fl, mm, fx);
    check("R8 wrong tree key 0 flip count", fl, 2048);
    check("R5 tree sweep vs model", mm, 0);

    sweep(KP_OK, 4'h5, fl, mm, fx);
    check("R8 wrong tree key 5 flip count", fl, 2048);

    sweep(13'h0000, 4'h0, fl, mm, fx);
    check("R7 union count disjoint", fl, 2049);
    check("R7 union sweep vs model", mm, 0);

    sweep(13'h0005, 4'h0, fl, mm, fx);
    check("R7 union count overlapping", fl, 2048);

    apply(13'h0005, {KT_OK, KP_OK}, 1'b1);
    check("R4 R6 correct keys at tree-hit pattern", y_out, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule